// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the System Management Mode memory-protection controls of a host bridge and turns them into a routing decision for every memory request. A request carries an address, a write flag and a flag that says whether the processor is in SMM. The block answers, in the same cycle, whether the access goes to system RAM, to PCI/VGA space, or into a blackhole. It also gives the RAM address to use, since the high alias is remapped onto the legacy segment. The configured top of low memory is an input, and the TSEG region is placed directly below it.

Three registers are reached through a small configuration write port, and their current values are always visible on outputs:
- a control byte with open, closed, lock and global-enable bits;
- an extended control byte with high-enable, TSEG size and TSEG enable;
- a 16-bit size-query word.

Setting the lock bit is one-way until reset. It clears the open bit and freezes the protected fields. Non-SMM accesses that land in TSEG read as all ones on the full 32-bit word, whatever the access size, and their writes never reach RAM.

Top module: `smm_guard`

## Requirements
- R1: After reset the control byte reads 0x02, the extended byte reads 0x00, and the query word reads 0xFFFF (when the extended size is nonzero).
- R2: Control byte fields are open [6], closed [5], lock [4] and global enable [3]. Bits [2:0] are read-only 3'b010. Extended byte fields are high enable [7], TSEG size [2:1] and TSEG enable [0]. Its other bits are read-only zero. Before the lock, writes with cfg_sel 0 and 1 update every writable bit.
- R3: Once lock is 1, open reads 0, lock stays 1 until reset, only the closed bit of the control byte can still be written, and the extended byte ignores writes.
- R4: For non-SMM requests, the legacy window 0xA0000–0xBFFFF routes to RAM only when open=1 and high enable=0. Otherwise it routes to PCI.
- R5: For non-SMM requests, the high alias 0xFEDA0000–0xFEDBFFFF routes to RAM only when open=1 and high enable=1, with ram_addr = addr - 0xFEDA0000 + 0xA0000. Otherwise it follows the default routing.
- R6: For SMM requests with global enable=1, the legacy window goes to RAM when high enable=0, and the high alias goes to RAM (remapped) when high enable=1. The other window, and all windows when global enable=0, route exactly as for a non-SMM request.
- R7: TSEG size is 0 when TSEG enable=0. When it is 1, size codes 0, 1, 2 and 3 give 1 MB, 2 MB, 8 MB and the extended size (default 16 MB).
- R8: TSEG is [tolm - size, tolm). There, non-SMM requests route to blackhole (route=2) with rd_data=0xFFFFFFFF and ram_we=0, and SMM requests route to RAM.
- R9: A write of 0xFFFF to the query word (cfg_sel 2) makes it read the extended size in megabytes. Any other written value is stored as written.
- R10: Outside all windows an address below tolm routes to RAM (route=0), otherwise to PCI (route=1). rd_data is 0 for any route other than blackhole, and ram_we equals req_wr when routed to RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset, the only way to clear the lock |
| cfg_we | input | 1 | register write strobe |
| cfg_sel | input | 2 | register select: 0 control, 1 extended, 2 query |
| cfg_wdata | input | 16 | write data (bytes use bits [7:0]) |
| ctl_q | output | 8 | control byte value |
| ext_q | output | 8 | extended control byte value |
| qry_q | output | 16 | size-query word value |
| tolm | input | 32 | top of low memory (byte address) |
| req_addr | input | 32 | request byte address |
| req_smm | input | 1 | request issued in SMM |
| req_wr | input | 1 | request is a write |
| route | output | 2 | 0 RAM, 1 PCI, 2 blackhole |
| ram_addr | output | 32 | RAM address after alias remapping |
| ram_we | output | 1 | write reaches RAM |
| rd_data | output | 32 | blackhole read data, zero otherwise |

## Verification
The checker watches these on every cycle:
- the lock never releases, and open never reads 1 while locked;
- the extended byte stays frozen after the lock;
- a blackhole route never comes from an SMM request, and it always pairs with all-ones data and a suppressed write;
- with TSEG disabled, no blackhole is ever produced.

The bench scenarios are needed for the rest:
- whether each open/high/global combination sends each window to the right target, and whether the alias remap address is correct;
- whether the TSEG bounds fall exactly at tolm minus each size code;
- whether the query handshake returns the extended size.

// File: rtl/smm_pkg.sv
package smm_pkg;
   typedef enum logic [1:0] {
      RT_RAM   = 2'd0,
      RT_PCI   = 2'd1,
      RT_BHOLE = 2'd2
   } route_t;

   // control byte fields
   localparam int CB_OPEN   = 6;
   localparam int CB_CLOSED = 5;
   localparam int CB_LOCK   = 4;
   localparam int CB_GEN    = 3;
   localparam logic [7:0] CB_FIXED  = 8'h02;
   localparam logic [7:0] CB_WM     = 8'h78;
   localparam logic [7:0] CB_WM_LCK = 8'h20;

   // extended byte fields
   localparam int XB_HIGH = 7;
   localparam int XB_SZ_L = 1;
   localparam int XB_TEN  = 0;
   localparam logic [7:0] XB_WM     = 8'h87;
   localparam logic [7:0] XB_WM_LCK = 8'h00;

   // register selects
   localparam logic [1:0] SEL_CTL = 2'd0;
   localparam logic [1:0] SEL_EXT = 2'd1;
   localparam logic [1:0] SEL_QRY = 2'd2;
endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
   import smm_pkg::*;
#(
   parameter int          QW     = 16,
   parameter int          EXT_MB = 16,
   parameter logic [15:0] QCODE  = 16'hFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    sel,
   input  logic [QW-1:0] wdata,
   output logic [7:0]    ctl,
   output logic [7:0]    ext,
   output logic [QW-1:0] qry
);
   logic       locked;
   logic [7:0] cmask, xmask, ctl_nx;

   assign locked = ctl[CB_LOCK];
   assign cmask  = locked ? CB_WM_LCK : CB_WM;
   assign xmask  = locked ? XB_WM_LCK : XB_WM;

   always_comb begin
      ctl_nx = (ctl & ~cmask) | (wdata[7:0] & cmask);
      if (ctl_nx[CB_LOCK]) ctl_nx[CB_OPEN] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= CB_FIXED;
         ext <= 8'h00;
      end else if (we) begin
         if (sel == SEL_CTL) ctl <= ctl_nx;
         if (sel == SEL_EXT) ext <= (ext & ~xmask) | (wdata[7:0] & xmask);
      end
   end

   generate
      if (EXT_MB > 0) begin : g_query
         localparam logic [QW-1:0] QC  = QW'(QCODE);
         localparam logic [QW-1:0] EMB = QW'(EXT_MB);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               qry <= QC;
            else if (we && sel == SEL_QRY)
               qry <= (wdata == QC) ? EMB : wdata;
         end
      end else begin : g_noquery
         assign qry = '0;
      end
   endgenerate
endmodule

// File: rtl/smm_tseg_calc.sv
module smm_tseg_calc
   import smm_pkg::*;
#(
   parameter int AW      = 32,
   parameter int EXT_MB  = 16,
   parameter int SZ0_MB  = 1,
   parameter int SZ1_MB  = 2,
   parameter int SZ2_MB  = 8
) (
   input  logic [7:0]    ext,
   input  logic [AW-1:0] tolm,
   output logic          ts_on,
   output logic [AW-1:0] ts_base
);
   localparam int MB_SH = 20;
   logic [AW-1:0] mb;

   always_comb begin
      unique case (ext[XB_SZ_L +: 2])
         2'd0:    mb = AW'(SZ0_MB);
         2'd1:    mb = AW'(SZ1_MB);
         2'd2:    mb = AW'(SZ2_MB);
         default: mb = AW'(EXT_MB);
      endcase
      if (!ext[XB_TEN]) mb = '0;
   end

   assign ts_on   = (mb != '0);
   assign ts_base = tolm - (mb << MB_SH);
endmodule

// File: rtl/smm_route.sv
module smm_route
   import smm_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            DW       = 32,
   parameter logic [31:0]   LEG_BASE = 32'h000A_0000,
   parameter logic [31:0]   WIN_SIZE = 32'h0002_0000,
   parameter logic [31:0]   HI_BASE  = 32'hFEDA_0000
) (
   input  logic [7:0]    ctl,
   input  logic [7:0]    ext,
   input  logic          ts_on,
   input  logic [AW-1:0] ts_base,
   input  logic [AW-1:0] tolm,
   input  logic [AW-1:0] addr,
   input  logic          smm,
   input  logic          wr,
   output logic [1:0]    route,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] rd_data
);
   localparam logic [AW-1:0] LB = AW'(LEG_BASE);
   localparam logic [AW-1:0] LE = AW'(LEG_BASE + WIN_SIZE);
   localparam logic [AW-1:0] HB = AW'(HI_BASE);
   localparam logic [AW-1:0] HE = AW'(HI_BASE + WIN_SIZE);

   logic          in_leg, in_hi, in_ts, opn, hen, gen;
   logic [AW-1:0] hi_map;
   route_t        ns_rt, sm_rt, rt;
   logic [AW-1:0] ns_ad, sm_ad;

   assign opn    = ctl[CB_OPEN];
   assign gen    = ctl[CB_GEN];
   assign hen    = ext[XB_HIGH];
   assign in_leg = (addr >= LB) && (addr < LE);
   assign in_hi  = (addr >= HB) && (addr < HE);
   assign in_ts  = ts_on && (addr >= ts_base) && (addr < tolm);
   assign hi_map = addr - HB + LB;

   always_comb begin
      ns_rt = (addr < tolm) ? RT_RAM : RT_PCI;
      ns_ad = addr;
      if (in_hi && opn && hen) begin
         ns_rt = RT_RAM;
         ns_ad = hi_map;
      end else if (in_leg) begin
         ns_rt = (opn && !hen) ? RT_RAM : RT_PCI;
      end else if (in_ts) begin
         ns_rt = RT_BHOLE;
      end

      sm_rt = ns_rt;
      sm_ad = ns_ad;
      if (gen && !hen && in_leg) begin
         sm_rt = RT_RAM;
         sm_ad = addr;
      end else if (gen && hen && in_hi) begin
         sm_rt = RT_RAM;
         sm_ad = hi_map;
      end else if (in_ts) begin
         sm_rt = RT_RAM;
         sm_ad = addr;
      end

      rt       = smm ? sm_rt : ns_rt;
      ram_addr = smm ? sm_ad : ns_ad;
   end

   assign route   = rt;
   assign ram_we  = wr && (rt == RT_RAM);
   assign rd_data = (rt == RT_BHOLE) ? '1 : '0;
endmodule

// File: rtl/smm_guard.sv
module smm_guard
   import smm_pkg::*;
#(
   parameter int          AW     = 32,
   parameter int          DW     = 32,
   parameter int          QW     = 16,
   parameter int          EXT_MB = 16,
   parameter int          EXT_MAX = 4095,
   parameter logic [15:0] QCODE  = 16'hFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [QW-1:0] cfg_wdata,
   output logic [7:0]    ctl_q,
   output logic [7:0]    ext_q,
   output logic [QW-1:0] qry_q,
   input  logic [AW-1:0] tolm,
   input  logic [AW-1:0] req_addr,
   input  logic          req_smm,
   input  logic          req_wr,
   output logic [1:0]    route,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] rd_data
);
   generate
      if (EXT_MB < 0 || EXT_MB > EXT_MAX) begin : g_bad_ext
         $error("smm_guard: EXT_MB out of range");
      end
      if (AW != 32) begin : g_bad_aw
         $error("smm_guard: window constants need AW of 32");
      end
      if (QW < 16) begin : g_bad_qw
         $error("smm_guard: query word must be at least 16 bits");
      end
   endgenerate

   logic          ts_on;
   logic [AW-1:0] ts_base;

   smm_cfg_regs #(.QW(QW), .EXT_MB(EXT_MB), .QCODE(QCODE)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .ctl(ctl_q), .ext(ext_q), .qry(qry_q)
   );

   smm_tseg_calc #(.AW(AW), .EXT_MB(EXT_MB)) u_tseg (
      .ext(ext_q), .tolm(tolm), .ts_on(ts_on), .ts_base(ts_base)
   );

   smm_route #(.AW(AW), .DW(DW)) u_route (
      .ctl(ctl_q), .ext(ext_q), .ts_on(ts_on), .ts_base(ts_base), .tolm(tolm),
      .addr(req_addr), .smm(req_smm), .wr(req_wr),
      .route(route), .ram_addr(ram_addr), .ram_we(ram_we), .rd_data(rd_data)
   );
endmodule

// File: rtl/smm_guard_chk.sv
module smm_guard_chk
   import smm_pkg::*;
#(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    ctl_q,
   input logic [7:0]    ext_q,
   input logic          req_smm,
   input logic          req_wr,
   input logic [1:0]    route,
   input logic          ram_we,
   input logic [DW-1:0] rd_data
);
   assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CB_LOCK] |=> ctl_q[CB_LOCK]);

   assert_lock_clears_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CB_LOCK] |-> !ctl_q[CB_OPEN]);

   assert_ext_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CB_LOCK] |=> $stable(ext_q));

   assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[2:0] == 3'b010);

   assert_bhole_not_smm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      route == 2'(RT_BHOLE) |-> !req_smm && !ram_we && (rd_data == {DW{1'b1}}));

   assert_no_bhole_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_q[XB_TEN] |-> route != 2'(RT_BHOLE));

   assert_route_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      route != 2'd3);

   assert_ram_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (route == 2'(RT_RAM) && req_wr) |-> ram_we);
endmodule

bind smm_guard smm_guard_chk #(.DW(DW)) i_chk (
   .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .ext_q(ext_q), .req_smm(req_smm),
   .req_wr(req_wr), .route(route), .ram_we(ram_we), .rd_data(rd_data)
);

// File: tb/test_smm_guard.sv
`timescale 1ns/1ps
module test_smm_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = '0;
   logic [7:0]  ctl_q, ext_q;
   logic [15:0] qry_q;
   logic [31:0] tolm = 32'h8000_0000;
   logic [31:0] req_addr = '0;
   logic        req_smm = 1'b0, req_wr = 1'b0;
   logic [1:0]  route;
   logic [31:0] ram_addr, rd_data;
   logic        ram_we;

   int n_chk = 0, n_bad = 0;
   logic [7:0]  m_ctl, m_ext;
   logic [15:0] m_qry;

   always #2.5 clk = ~clk;

   smm_guard i_smm_guard (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ctl_q(ctl_q), .ext_q(ext_q), .qry_q(qry_q),
      .tolm(tolm), .req_addr(req_addr), .req_smm(req_smm), .req_wr(req_wr),
      .route(route), .ram_addr(ram_addr), .ram_we(ram_we), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      m_ctl = 8'h02; m_ext = 8'h00; m_qry = 16'hFFFF;
   endtask

   // reference register model
   task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] d);
      logic [7:0] msk;
      bit lk;
      lk = m_ctl[4];
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel == 2'd0) begin
         msk = lk ? 8'h20 : 8'h78;
         m_ctl = (m_ctl & ~msk) | (d[7:0] & msk);
         if (m_ctl[4]) m_ctl[6] = 1'b0;
      end else if (sel == 2'd1) begin
         msk = lk ? 8'h00 : 8'h87;
         m_ext = (m_ext & ~msk) | (d[7:0] & msk);
      end else if (sel == 2'd2) begin
         m_qry = (d == 16'hFFFF) ? 16'd16 : d;
      end
   endtask

   function automatic logic [31:0] tseg_bytes(input logic [7:0] x);
      if (!x[0]) return 32'd0;
      case (x[2:1])
         2'd0: return 32'd1 << 20;
         2'd1: return 32'd2 << 20;
         2'd2: return 32'd8 << 20;
         default: return 32'd16 << 20;
      endcase
   endfunction

   // expected {route, ram address}
   function automatic logic [33:0] ref_route(input logic [31:0] a, input bit smm,
                                             input logic [7:0] c, input logic [7:0] x,
                                             input logic [31:0] top);
      bit leg, hi, ts, op, he, ge;
      logic [31:0] sz;
      logic [1:0] r;
      logic [31:0] ra;
      op = c[6]; ge = c[3]; he = x[7];
      sz = tseg_bytes(x);
      leg = a >= 32'hA0000 && a < 32'hC0000;
      hi  = a >= 32'hFEDA0000 && a < 32'hFEDC0000;
      ts  = sz != 0 && a >= top - sz && a < top;
      ra = a;
      if (smm && ge && !he && leg) r = 2'd0;
      else if (smm && ge && he && hi) begin r = 2'd0; ra = a - 32'hFEDA0000 + 32'hA0000; end
      else if (hi && op && he) begin r = 2'd0; ra = a - 32'hFEDA0000 + 32'hA0000; end
      else if (leg) r = (op && !he) ? 2'd0 : 2'd1;
      else if (ts) r = smm ? 2'd0 : 2'd2;
      else r = (a < top) ? 2'd0 : 2'd1;
      return {r, ra};
   endfunction

   task automatic probe(input logic [31:0] a, input bit smm, input bit w, input string tag);
      logic [33:0] e;
      @(negedge clk);
      req_addr = a; req_smm = smm; req_wr = w;
      #1;
      e = ref_route(a, smm, m_ctl, m_ext, tolm);
      chk(route == e[33:32], tag, {30'd0, route}, {30'd0, e[33:32]});
      if (e[33:32] == 2'd0)
         chk(ram_addr == e[31:0], tag, ram_addr, e[31:0]);
      chk(rd_data == ((e[33:32] == 2'd2) ? 32'hFFFF_FFFF : 32'h0), "R8/R10 rd_data",
          rd_data, (e[33:32] == 2'd2) ? 32'hFFFF_FFFF : 32'h0);
      chk(ram_we == (w && e[33:32] == 2'd0), "R8/R10 ram_we", {31'd0, ram_we},
          {31'd0, w && e[33:32] == 2'd0});
   endtask

   task automatic chk_regs(input string tag);
      #1;
      chk(ctl_q == m_ctl, tag, {24'd0, ctl_q}, {24'd0, m_ctl});
      chk(ext_q == m_ext, tag, {24'd0, ext_q}, {24'd0, m_ext});
      chk(qry_q == m_qry, tag, {16'd0, qry_q}, {16'd0, m_qry});
   endtask

   function automatic logic [31:0] pick_addr(input int k);
      case (k % 6)
         0: return 32'hA0000 + ($urandom % 32'h20000);
         1: return 32'hFEDA0000 + ($urandom % 32'h20000);
         2: return tolm - 32'h100000 * 32'($urandom % 17) + 32'($urandom % 8);
         3: return $urandom % tolm;
         4: return tolm + ($urandom % 32'h1000_0000);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset();
      chk_regs("R1 reset values");

      // R2 plain writes, read-only bits
      wr_cfg(2'd0, 16'hFFFF & 16'h00EF);
      wr_cfg(2'd1, 16'h00FF);
      chk_regs("R2 masked writes");

      // R4 R5 R6 sweep of open/high/global for both modes
      for (int v = 0; v < 8; v++) begin
         wr_cfg(2'd0, {8'h00, 1'b0, v[0], 2'b00, v[2], 3'b000});
         wr_cfg(2'd1, {8'h00, v[1], 7'h00});
         for (int s = 0; s < 2; s++) begin
            probe(32'hA8000, s[0], 1'b1, "R4/R6 legacy window");
            probe(32'hFEDB0004, s[0], 1'b0, "R5/R6 high alias");
            probe(32'h0010_0000, s[0], 1'b0, "R10 default low");
         end
      end

      // R7 R8 TSEG sizes and bounds
      tolm = 32'h4000_0000;
      for (int c = 0; c < 4; c++) begin
         wr_cfg(2'd1, {8'h00, 5'd0, c[1:0], 1'b1});
         probe(tolm - tseg_bytes(m_ext), 1'b0, 1'b1, "R7/R8 tseg base");
         probe(tolm - tseg_bytes(m_ext) - 1, 1'b0, 1'b1, "R7 below tseg");
         probe(tolm - 1, 1'b0, 1'b0, "R8 tseg top");
         probe(tolm - 4, 1'b1, 1'b1, "R8 smm in tseg");
         probe(tolm, 1'b0, 1'b0, "R10 at tolm");
      end
      wr_cfg(2'd1, 16'h0006);
      probe(tolm - 1, 1'b0, 1'b0, "R7 tseg disabled");

      // R9 query handshake
      chk_regs("R9 before query");
      wr_cfg(2'd2, 16'h1234);
      chk_regs("R9 plain store");
      wr_cfg(2'd2, 16'hFFFF);
      chk_regs("R9 query returns size");

      // random phase, unlocked
      for (int i = 0; i < 300; i++) begin
         tolm = 32'h1000_0000 * 32'(1 + $urandom % 8);
         wr_cfg(2'd0, 16'($urandom) & 16'hFFEF);
         wr_cfg(2'd1, 16'($urandom));
         probe(pick_addr(i), 1'($urandom), 1'($urandom), "R4-R8 random");
      end

      // R3 lock behaviour
      wr_cfg(2'd0, 16'h0048);
      wr_cfg(2'd1, 16'h0083);
      chk_regs("R3 pre-lock");
      wr_cfg(2'd0, 16'h0058);
      chk_regs("R3 lock clears open");
      wr_cfg(2'd0, 16'h0040);
      chk_regs("R3 only closed writable");
      wr_cfg(2'd0, 16'h0020);
      chk_regs("R3 closed still writable");
      wr_cfg(2'd1, 16'h0000);
      chk_regs("R3 ext frozen");
      probe(32'hA0010, 1'b0, 1'b1, "R3/R4 locked legacy");
      probe(32'hFEDA0010, 1'b1, 1'b0, "R3/R6 locked smm alias");
      do_reset();
      chk_regs("R1 reset clears lock");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule